// File: doc/BRIEF.md
# Virtually Indexed Write-Back Cache

This block is a small two-way set-associative data cache that looks up byte requests by their 16-bit virtual address. It uses that address with no translation. It holds 64 bytes as eight lines of 8 bytes, arranged as four sets of two ways. Each set has one bit that names the way to evict next. A store changes only the cached copy and marks the line dirty. The line reaches memory only when it is evicted or flushed.

Requests enter on a valid/ready stream. A request moves on the cycle in which `req_valid` and `req_ready` are both high. `req_ready` stays low while the cache is busy with a refill, an eviction or a flush. It also stays low while `flush` is high. The response is a one-cycle pulse on `rsp_valid` with no back-pressure, so the requester must take it on that cycle.

On a miss the cache picks a victim way. If the victim holds dirty data, the cache first sends that data to memory one byte per beat. It then fetches the new line one byte per beat. A beat on the memory port completes in a cycle where `mem_valid` and `mem_ready` are both high. On a read beat, `mem_rdata` must be valid in that same cycle.

Top module: `vic_cache`

## Requirements
- R1: An address is split into a byte offset in bits [2:0], a set number in bits [4:3] and a tag in bits [15:5]. Every lookup uses these virtual fields directly. Two addresses with the same set and different tags never hit on each other's line.
- R2: A request that hits gives `rsp_valid`=1 and `rsp_hit`=1 in the cycle right after it is accepted. On a read, `rsp_rdata` is the stored byte. On a write, `rsp_rdata` echoes the write data.
- R3: A write hit changes only the cached byte and marks the line dirty. It causes no memory beat.
- R4: On a miss, if a way of the set is invalid, that way is filled. The invalid way with the lower number is used first.
- R5: A hit in way w, or a fill of way w, makes the other way the next victim of that set.
- R6: On a miss whose victim is valid and dirty, all 8 bytes of the victim go to memory as write beats at the victim's own address. Only then does the first read beat of the fill start. A miss on a clean or invalid victim makes no write beats. Every miss makes exactly 8 read beats.
- R7: A write miss fetches the whole line, merges the written byte into it, and leaves the line dirty.
- R8: While a miss or a flush is in progress, `busy`=1 and `req_ready`=0. If memory is always ready, a miss answers 10 cycles after acceptance, or 18 cycles if a dirty victim is written back. Both answers have `rsp_hit`=0.
- R9: A memory beat advances only when `mem_ready`=1. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_write` and `mem_addr` hold their values.
- R10: A one-cycle `flush` pulse while the cache is idle sends every dirty line to memory. It then clears every valid bit, so the next access to any cached address misses. `busy` stays high until the flush is complete.
- R11: After reset, all lines are invalid, `busy`=0, `req_ready`=1, and `rsp_valid` and `mem_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 16 | Virtual byte address |
| req_wdata | input | 8 | Store data |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_hit | output | 1 | The response came from a hit |
| rsp_rdata | output | 8 | Loaded byte, or echoed store byte |
| flush | input | 1 | Write back dirty lines and invalidate all lines |
| busy | output | 1 | A miss or a flush is in progress |
| mem_valid | output | 1 | Memory beat offered |
| mem_ready | input | 1 | Memory takes the beat this cycle |
| mem_write | output | 1 | 1 = write-back beat, 0 = fill beat |
| mem_addr | output | 16 | Byte address of the beat |
| mem_wdata | output | 8 | Write-back byte |
| mem_rdata | input | 8 | Fill byte, valid during an accepted read beat |

## Verification
A hit is due at the first falling edge after the accepting clock edge. With memory always ready, a clean miss is due at the tenth falling edge after acceptance and a dirty miss at the eighteenth. The bench counts falling edges from acceptance and compares that count with the figure in each vector. Memory traffic is checked by counting write and read beats over each request and over each flush. Under stalled memory, only data and beat counts are checked, because the latency then depends on the stall pattern.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WB,
    ST_FILL,
    ST_DONE,
    ST_FSCAN,
    ST_FWB
  } vic_state_e;
endpackage

// File: rtl/vic_tag_store.sv
module vic_tag_store #(
  parameter int NUM_SETS = 4,
  parameter int TAG_W    = 11,
  localparam int SET_W   = $clog2(NUM_SETS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [SET_W-1:0]      set_i,
  output logic [1:0][TAG_W-1:0] tag_o,
  output logic [1:0]            valid_o,
  output logic [1:0]            dirty_o,
  output logic                  lru_o,
  input  logic                  upd_en,
  input  logic                  upd_way,
  input  logic [TAG_W-1:0]      upd_tag,
  input  logic                  upd_valid,
  input  logic                  upd_dirty,
  input  logic                  lru_en,
  input  logic                  lru_val,
  input  logic                  clr_all
);
  logic [NUM_SETS-1:0] lru_q;

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [TAG_W-1:0]    tag_q [NUM_SETS];
    logic [NUM_SETS-1:0] val_q;
    logic [NUM_SETS-1:0] dty_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
        dty_q <= '0;
      end else if (clr_all) begin
        val_q <= '0;
        dty_q <= '0;
      end else if (upd_en && upd_way == 1'(w)) begin
        val_q[set_i] <= upd_valid;
        dty_q[set_i] <= upd_dirty;
      end
    end

    always_ff @(posedge clk) begin
      if (upd_en && upd_way == 1'(w)) tag_q[set_i] <= upd_tag;
    end

    assign tag_o[w]   = tag_q[set_i];
    assign valid_o[w] = val_q[set_i];
    assign dirty_o[w] = dty_q[set_i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lru_q <= '0;
    else if (clr_all) lru_q <= '0;
    else if (lru_en)  lru_q[set_i] <= lru_val;
  end

  assign lru_o = lru_q[set_i];

  // R10: a flush leaves no valid line behind
  p_flush_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_all |=> ($countones({g_way[1].val_q, g_way[0].val_q}) == 0));
endmodule

// File: rtl/vic_data_store.sv
module vic_data_store #(
  parameter int NUM_SETS   = 4,
  parameter int LINE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int DEPTH     = NUM_SETS * 2 * LINE_BYTES
) (
  input  logic              clk,
  input  logic [SET_W-1:0]  set_i,
  input  logic              rd_way,
  input  logic [OFF_W-1:0]  rd_off,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_en,
  input  logic              wr_way,
  input  logic [OFF_W-1:0]  wr_off,
  input  logic [DATA_W-1:0] wr_data
);
  logic [DATA_W-1:0] bytes_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) bytes_q[{set_i, wr_way, wr_off}] <= wr_data;
  end

  assign rd_data = bytes_q[{set_i, rd_way, rd_off}];
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int NUM_SETS   = 4,
  parameter int LINE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [DATA_W-1:0]     rsp_rdata,
  input  logic                  flush,
  output logic                  busy,
  output logic                  mem_valid,
  input  logic                  mem_ready,
  output logic                  mem_write,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_wdata,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [SET_W-1:0]      set_sel,
  input  logic [1:0][TAG_W-1:0] tag_i,
  input  logic [1:0]            valid_i,
  input  logic [1:0]            dirty_i,
  input  logic                  lru_i,
  output logic                  upd_en,
  output logic                  upd_way,
  output logic [TAG_W-1:0]      upd_tag,
  output logic                  upd_valid,
  output logic                  upd_dirty,
  output logic                  lru_en,
  output logic                  lru_val,
  output logic                  clr_all,
  output logic                  d_rd_way,
  output logic [OFF_W-1:0]      d_rd_off,
  input  logic [DATA_W-1:0]     d_rd_data,
  output logic                  d_wr_en,
  output logic                  d_wr_way,
  output logic [OFF_W-1:0]      d_wr_off,
  output logic [DATA_W-1:0]     d_wr_data
);
  localparam logic [OFF_W-1:0] LAST_BEAT = OFF_W'(LINE_BYTES - 1);
  localparam logic [SET_W:0]   LAST_LINE = '1;

  vic_state_e        state;
  logic [ADDR_W-1:0] r_addr;
  logic              r_write;
  logic [DATA_W-1:0] r_wdata;
  logic              r_way;
  logic [OFF_W-1:0]  beat;
  logic [SET_W:0]    fl_idx;

  logic [SET_W-1:0] req_set, r_set, fl_set;
  logic [TAG_W-1:0] req_tag, r_tag;
  logic [OFF_W-1:0] req_off, r_off;
  logic             fl_way, in_flush, cur_way, last_beat;
  logic [1:0]       hit_w;
  logic             lookup_hit, hit_way, vict, accept, fl_dirty;

  assign req_off = req_addr[OFF_W-1:0];
  assign req_set = req_addr[OFF_W +: SET_W];
  assign req_tag = req_addr[ADDR_W-1 -: TAG_W];
  assign r_off   = r_addr[OFF_W-1:0];
  assign r_set   = r_addr[OFF_W +: SET_W];
  assign r_tag   = r_addr[ADDR_W-1 -: TAG_W];
  assign fl_set  = fl_idx[SET_W:1];
  assign fl_way  = fl_idx[0];

  assign in_flush  = (state == ST_FSCAN) || (state == ST_FWB);
  assign set_sel   = in_flush ? fl_set : ((state == ST_IDLE) ? req_set : r_set);
  assign cur_way   = in_flush ? fl_way : r_way;
  assign last_beat = (beat == LAST_BEAT);
  assign fl_dirty  = valid_i[fl_way] && dirty_i[fl_way];

  for (genvar w = 0; w < 2; w++) begin : g_cmp
    assign hit_w[w] = valid_i[w] && (tag_i[w] == req_tag);
  end
  assign lookup_hit = |hit_w;
  assign hit_way    = hit_w[1];
  assign vict       = !valid_i[0] ? 1'b0 : (!valid_i[1] ? 1'b1 : lru_i);

  assign req_ready = (state == ST_IDLE) && !flush;
  assign busy      = (state != ST_IDLE);
  assign accept    = req_valid && req_ready;

  // memory port
  assign mem_valid = (state == ST_WB) || (state == ST_FILL) || (state == ST_FWB);
  assign mem_write = (state == ST_WB) || (state == ST_FWB);
  assign mem_addr  = mem_write ? {tag_i[cur_way], set_sel, beat} : {r_tag, r_set, beat};
  assign mem_wdata = d_rd_data;

  // data read port
  assign d_rd_way = (state == ST_IDLE) ? hit_way : cur_way;
  assign d_rd_off = mem_write ? beat : ((state == ST_IDLE) ? req_off : r_off);

  always_comb begin
    upd_en    = 1'b0;
    upd_way   = 1'b0;
    upd_tag   = '0;
    upd_valid = 1'b0;
    upd_dirty = 1'b0;
    lru_en    = 1'b0;
    lru_val   = 1'b0;
    clr_all   = 1'b0;
    d_wr_en   = 1'b0;
    d_wr_way  = 1'b0;
    d_wr_off  = '0;
    d_wr_data = '0;
    unique case (state)
      ST_IDLE: if (accept && lookup_hit) begin
        lru_en  = 1'b1;
        lru_val = ~hit_way;
        if (req_write) begin
          d_wr_en   = 1'b1;
          d_wr_way  = hit_way;
          d_wr_off  = req_off;
          d_wr_data = req_wdata;
          upd_en    = 1'b1;
          upd_way   = hit_way;
          upd_tag   = req_tag;
          upd_valid = 1'b1;
          upd_dirty = 1'b1;
        end
      end
      ST_FILL: if (mem_ready) begin
        d_wr_en   = 1'b1;
        d_wr_way  = r_way;
        d_wr_off  = beat;
        d_wr_data = mem_rdata;
        if (last_beat) begin
          upd_en    = 1'b1;
          upd_way   = r_way;
          upd_tag   = r_tag;
          upd_valid = 1'b1;
        end
      end
      ST_DONE: begin
        lru_en  = 1'b1;
        lru_val = ~r_way;
        if (r_write) begin
          d_wr_en   = 1'b1;
          d_wr_way  = r_way;
          d_wr_off  = r_off;
          d_wr_data = r_wdata;
          upd_en    = 1'b1;
          upd_way   = r_way;
          upd_tag   = r_tag;
          upd_valid = 1'b1;
          upd_dirty = 1'b1;
        end
      end
      ST_FWB: if (mem_ready && last_beat) begin
        upd_en    = 1'b1;
        upd_way   = fl_way;
        upd_tag   = tag_i[fl_way];
        upd_valid = 1'b1;
      end
      ST_FSCAN: if (!fl_dirty && fl_idx == LAST_LINE) clr_all = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      r_addr    <= '0;
      r_write   <= 1'b0;
      r_wdata   <= '0;
      r_way     <= 1'b0;
      beat      <= '0;
      fl_idx    <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            r_addr  <= req_addr;
            r_write <= req_write;
            r_wdata <= req_wdata;
            if (lookup_hit) begin
              rsp_valid <= 1'b1;
              rsp_hit   <= 1'b1;
              rsp_rdata <= req_write ? req_wdata : d_rd_data;
            end else begin
              r_way <= vict;
              beat  <= '0;
              state <= (valid_i[vict] && dirty_i[vict]) ? ST_WB : ST_FILL;
            end
          end else if (flush) begin
            fl_idx <= '0;
            state  <= ST_FSCAN;
          end
        end
        ST_WB: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= ST_FILL;
        end
        ST_FILL: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= ST_DONE;
        end
        ST_DONE: begin
          rsp_valid <= 1'b1;
          rsp_hit   <= 1'b0;
          rsp_rdata <= r_write ? r_wdata : d_rd_data;
          state     <= ST_IDLE;
        end
        ST_FSCAN: begin
          if (fl_dirty) begin
            beat  <= '0;
            state <= ST_FWB;
          end else if (fl_idx == LAST_LINE) begin
            state <= ST_IDLE;
          end else begin
            fl_idx <= fl_idx + 1'b1;
          end
        end
        ST_FWB: if (mem_ready) begin
          beat <= beat + 1'b1;
          if (last_beat) state <= ST_FSCAN;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a lookup hit is answered on the following cycle
  p_hit_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && lookup_hit) |=> (rsp_valid && rsp_hit));

  // R4: an invalid way 0 is chosen for the fill
  p_first_invalid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !lookup_hit && !valid_i[0]) |=> (busy && !r_way));

  // R6: a fill read only follows the final accepted write-back beat
  p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_write && $past(mem_valid && mem_write))
      |-> ($past(mem_ready) && $past(mem_addr[OFF_W-1:0]) == LAST_BEAT));

  // R9: an offered beat is held until memory takes it
  p_mem_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_write)));
endmodule

// File: rtl/vic_cache.sv
module vic_cache #(
  parameter int ADDR_W     = 16,
  parameter int NUM_SETS   = 4,
  parameter int LINE_BYTES = 8,
  parameter int DATA_W     = 8,
  localparam int SET_W     = $clog2(NUM_SETS),
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - SET_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              flush,
  output logic              busy,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_write,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  logic [SET_W-1:0]      set_sel;
  logic [1:0][TAG_W-1:0] tags;
  logic [1:0]            valids, dirtys;
  logic                  lru;
  logic                  upd_en, upd_way, upd_valid, upd_dirty;
  logic [TAG_W-1:0]      upd_tag;
  logic                  lru_en, lru_val, clr_all;
  logic                  d_rd_way, d_wr_en, d_wr_way;
  logic [OFF_W-1:0]      d_rd_off, d_wr_off;
  logic [DATA_W-1:0]     d_rd_data, d_wr_data;

  vic_ctrl #(
    .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .flush(flush), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .set_sel(set_sel), .tag_i(tags), .valid_i(valids), .dirty_i(dirtys), .lru_i(lru),
    .upd_en(upd_en), .upd_way(upd_way), .upd_tag(upd_tag),
    .upd_valid(upd_valid), .upd_dirty(upd_dirty),
    .lru_en(lru_en), .lru_val(lru_val), .clr_all(clr_all),
    .d_rd_way(d_rd_way), .d_rd_off(d_rd_off), .d_rd_data(d_rd_data),
    .d_wr_en(d_wr_en), .d_wr_way(d_wr_way), .d_wr_off(d_wr_off), .d_wr_data(d_wr_data)
  );

  vic_tag_store #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .set_i(set_sel),
    .tag_o(tags), .valid_o(valids), .dirty_o(dirtys), .lru_o(lru),
    .upd_en(upd_en), .upd_way(upd_way), .upd_tag(upd_tag),
    .upd_valid(upd_valid), .upd_dirty(upd_dirty),
    .lru_en(lru_en), .lru_val(lru_val), .clr_all(clr_all)
  );

  vic_data_store #(.NUM_SETS(NUM_SETS), .LINE_BYTES(LINE_BYTES), .DATA_W(DATA_W)) u_data (
    .clk(clk), .set_i(set_sel),
    .rd_way(d_rd_way), .rd_off(d_rd_off), .rd_data(d_rd_data),
    .wr_en(d_wr_en), .wr_way(d_wr_way), .wr_off(d_wr_off), .wr_data(d_wr_data)
  );
endmodule

// File: tb/sim_vic_cache.sv
module sim_vic_cache;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;
  // {write, addr, wdata, expect_hit, expect_latency}
  localparam logic [33:0] VEC [NVEC] = '{
    {1'b0, 16'h0020, 8'h00, 1'b0, 8'd10},
    {1'b0, 16'h0025, 8'h00, 1'b1, 8'd1},
    {1'b1, 16'h0043, 8'hAA, 1'b0, 8'd10},
    {1'b0, 16'h0043, 8'h00, 1'b1, 8'd1},
    {1'b0, 16'h0021, 8'h00, 1'b1, 8'd1},
    {1'b0, 16'h0060, 8'h00, 1'b0, 8'd18},
    {1'b0, 16'h0043, 8'h00, 1'b0, 8'd10},
    {1'b0, 16'h0060, 8'h00, 1'b1, 8'd1},
    {1'b1, 16'h00AF, 8'h3C, 1'b0, 8'd10},
    {1'b1, 16'h00AF, 8'h5D, 1'b1, 8'd1},
    {1'b0, 16'h00AF, 8'h00, 1'b1, 8'd1},
    {1'b0, 16'hFFFF, 8'h00, 1'b0, 8'd10},
    {1'b0, 16'hFFFF, 8'h00, 1'b1, 8'd1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, flush = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, rsp_hit, busy, mem_valid, mem_write, mem_ready;
  logic [7:0]  rsp_rdata, mem_wdata, mem_rdata;
  logic [15:0] mem_addr;

  logic [7:0] bmem [65536];
  logic [7:0] shadow [65536];
  logic stall_mode = 1'b0, tog = 1'b0;
  int wr_beats = 0, rd_beats = 0;
  int n_checks = 0, n_fail = 0, cycles = 0;
  bit finished = 1'b0;

  vic_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_rdata(rsp_rdata),
    .flush(flush), .busy(busy),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory responder
  always @(negedge clk) tog <= ~tog;
  assign mem_ready = stall_mode ? tog : 1'b1;
  assign mem_rdata = bmem[mem_addr];
  always @(posedge clk) begin
    if (mem_valid && mem_ready) begin
      if (mem_write) begin
        bmem[mem_addr] <= mem_wdata;
        wr_beats <= wr_beats + 1;
      end else begin
        rd_beats <= rd_beats + 1;
      end
    end
  end

  task automatic check(input string req, input bit ok, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000 && !finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
      summary();
    end
  end

  task automatic do_req(input logic wr, input logic [15:0] a, input logic [7:0] d,
                        output int lat, output logic hit, output logic [7:0] rd,
                        output logic busy1, output logic rdy1);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    busy1 = busy; rdy1 = req_ready;
    lat = 1;
    while (!rsp_valid && lat < 400) begin
      @(negedge clk);
      lat++;
    end
    hit = rsp_hit; rd = rsp_rdata;
    if (wr) shadow[a] = d;
  endtask

  initial begin
    int lat, w0, r0;
    logic hit, b1, y1;
    logic [7:0] rd;
    for (int i = 0; i < 65536; i++) begin
      bmem[i]   = 8'(i) ^ 8'(i >> 8);
      shadow[i] = 8'(i) ^ 8'(i >> 8);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check("R11 ready", req_ready === 1'b1, req_ready, 1);
    check("R11 busy", busy === 1'b0, busy, 0);
    check("R11 rsp_valid", rsp_valid === 1'b0, rsp_valid, 0);
    check("R11 mem_valid", mem_valid === 1'b0, mem_valid, 0);

    // table walk (memory always ready)
    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] exp_d;
      w0 = wr_beats; r0 = rd_beats;
      exp_d = VEC[v][33] ? VEC[v][16:9] : shadow[VEC[v][32:17]];
      do_req(VEC[v][33], VEC[v][32:17], VEC[v][16:9], lat, hit, rd, b1, y1);
      check("R1 R4 R5 hit flag", hit === VEC[v][8], hit, VEC[v][8]);
      check("R2 R8 latency", lat == int'(VEC[v][7:0]), lat, VEC[v][7:0]);
      check("R2 R7 data", rd === exp_d, rd, exp_d);
      check("R3 R6 write beats", (wr_beats - w0) == (lat == 18 ? 8 : 0), wr_beats - w0,
            lat == 18 ? 8 : 0);
      check("R6 read beats", (rd_beats - r0) == (VEC[v][8] ? 0 : 8), rd_beats - r0,
            VEC[v][8] ? 0 : 8);
      if (!VEC[v][8]) check("R8 busy blocks ready", b1 && !y1, {b1, y1}, 2);
    end
    // R6: write-back landed at the victim address
    check("R6 written back", bmem[16'h0043] === 8'hAA, bmem[16'h0043], 8'hAA);

    // R10 flush under stalled memory
    stall_mode = 1'b1;
    w0 = wr_beats;
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check("R10 busy during flush", busy === 1'b1 && req_ready === 1'b0, busy, 1);
    while (busy) @(negedge clk);
    check("R10 flush write beats", (wr_beats - w0) == 8, wr_beats - w0, 8);
    check("R10 dirty byte saved", bmem[16'h00AF] === 8'h5D, bmem[16'h00AF], 8'h5D);
    stall_mode = 1'b0;
    do_req(1'b0, 16'h0060, 8'h00, lat, hit, rd, b1, y1);
    check("R10 miss after flush", hit === 1'b0 && lat == 10, lat, 10);
    check("R10 data after flush", rd === 8'h60, rd, 8'h60);

    // R9 stalled memory with a dirty eviction
    stall_mode = 1'b1;
    do_req(1'b1, 16'h0068, 8'h11, lat, hit, rd, b1, y1);
    check("R7 write miss", hit === 1'b0 && rd === 8'h11, rd, 8'h11);
    do_req(1'b1, 16'h00C8, 8'h22, lat, hit, rd, b1, y1);
    check("R4 second way", hit === 1'b0, hit, 0);
    do_req(1'b0, 16'h0068, 8'h00, lat, hit, rd, b1, y1);
    check("R4 first line kept", hit === 1'b1 && rd === 8'h11, rd, 8'h11);
    w0 = wr_beats;
    do_req(1'b0, 16'h00E8, 8'h00, lat, hit, rd, b1, y1);
    check("R9 stalled data", hit === 1'b0 && rd === 8'hE8, rd, 8'hE8);
    check("R5 R9 victim written", (wr_beats - w0) == 8 && bmem[16'h00C8] === 8'h22,
          bmem[16'h00C8], 8'h22);
    stall_mode = 1'b0;
    do_req(1'b0, 16'h0068, 8'h00, lat, hit, rd, b1, y1);
    check("R5 recent line kept", hit === 1'b1 && rd === 8'h11, rd, 8'h11);

    finished = 1'b1;
    summary();
  end
endmodule